// File: doc/BRIEF.md
# I2C Register Slave with Change Line

This block is a 100 kHz-class I2C-compatible slave that gives a host byte-wide access to a small register map. The host first opens a write transfer. The first data byte sets an internal pointer, and any further bytes land at successive locations. A read transfer then streams bytes out from wherever the pointer stands. The pointer steps by one after every byte moved in either direction, and it wraps at the top of the map.

The map has several kinds of location. Two locations are constant: an identity byte and a version byte. Five locations mirror a live status input. One location is a command trigger that starts a recalibration. The rest is plain read/write storage. An active-low change line goes low when the surrounding logic signals a status event. It goes high again only after the host has read every status byte. The two low bits of the slave address come from strap pins, so two or more devices can share a bus. Clock stretching and general call are not handled. A transfer is expected to finish with a STOP.

Top module: `i2c_regmap_slave`

## Requirements
- R1: While reset is held and just after it, `change_n` is 1, `sda_oe` is 0 and `calib_o` is 0.
- R2: The slave answers only the 7-bit address {BASE_ADDR[6:2], addr_sel}, received MSB first and followed by the R/W bit (1 = read). It acknowledges by driving SDA low during the ninth clock. With the defaults and `addr_sel`=2'b10 the address is 0x46.
- R3: In a write transfer, the first data byte loads the pointer from its low 4 bits. Each following byte is stored at the pointer, which then steps by one. Every data byte is acknowledged.
- R4: A read transfer sends bytes MSB first, starting at the current pointer. The pointer steps by one after each byte, so a later read continues where the last one stopped. The master's NACK ends the read.
- R5: Address 0 reads CHIP_ID (default 0x5C). Address 1 reads {VER_MAJOR, VER_MINOR}, major in bits 7:4 (default 0x42).
- R6: Addresses 0 to 6 are read-only, and writes to them have no effect. Addresses 2 to 6 return `status_i` bytes 0 to 4: address 2 returns bits 7:0, and each following address returns the next byte up.
- R7: The pointer wraps from 15 (DEPTH-1) back to 0.
- R8: Writing a nonzero byte to address 10 raises `calib_o` for exactly one clock cycle. Writing zero there raises nothing. Address 10 always reads 0x00.
- R9: A one-cycle `status_evt` pulse drives `change_n` low, and it stays low until it is released.
- R10: `change_n` returns high only once each of addresses 2, 3, 4, 5 and 6 has been read since the last event. The reads may come in any order and may be spread over several transfers.
- R11: When an event arrives in the same cycle as the read that would complete the status set, the event wins. `change_n` stays low, and the record of status reads starts again from empty.
- R12: A transfer with any other slave address gets no acknowledge. SDA is never driven during it, and nothing in the map changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Strap pins giving the two low slave-address bits |
| status_i | input | 40 | Live status bytes mirrored at addresses 2 to 6 |
| status_evt | input | 1 | One-cycle pulse reporting a status change |
| change_n | output | 1 | Active-low change line (open drain) |
| calib_o | output | 1 | One-cycle recalibration request |

## Verification
A status event and the read of the last outstanding status byte can fall in the same clock cycle. In that cycle the change tracker must decide both whether to release the line and whether to clear its read record. The bench aligns the two exactly. It pulses `status_evt` so that it is sampled on the edge where the design registers the SCL fall ending the eighth data bit of the read from address 6. It then judges the result at the ports. `change_n` must still be low after that read, still low after a fresh read of address 6 alone, and high only after all five status bytes have been read again.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int STAT_BYTES = 5;
    localparam int STAT_BASE  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } rs_state_e;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // data edges while the clock stays high mark bus conditions
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile
    import i2c_rs_pkg::*;
#(
    parameter int         DEPTH     = 16,
    parameter int         ADDR_W    = 4,
    parameter int         CAL_ADDR  = 10,
    parameter logic [7:0] CHIP_ID   = 8'h5C,
    parameter logic [3:0] VER_MAJOR = 4'd4,
    parameter logic [3:0] VER_MINOR = 4'd2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [8*STAT_BYTES-1:0] status_i,
    output logic [7:0]              rd_data,
    output logic                    calib_o
);
    localparam int FIRST_RW = STAT_BASE + STAT_BYTES;

    logic [7:0] cells [DEPTH];
    logic       calib_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        if (g == 0) begin : g_id
            assign cells[g] = CHIP_ID;
        end else if (g == 1) begin : g_ver
            assign cells[g] = {VER_MAJOR, VER_MINOR};
        end else if (g < FIRST_RW) begin : g_stat
            assign cells[g] = status_i[(g-STAT_BASE)*8 +: 8];
        end else if (g == CAL_ADDR) begin : g_cmd
            assign cells[g] = 8'h00;
        end else begin : g_rw
            logic [7:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= 8'h00;
                end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                    cell_q <= wr_data;
                end
            end
            assign cells[g] = cell_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calib_q <= 1'b0;
        end else begin
            calib_q <= wr_en && (wr_addr == ADDR_W'(CAL_ADDR)) && (wr_data != 8'h00);
        end
    end

    assign rd_data = cells[rd_addr];
    assign calib_o = calib_q;

endmodule

// File: rtl/i2c_rs_chg.sv
module i2c_rs_chg
    import i2c_rs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              change_n
);
    typedef struct packed {
        logic [STAT_BYTES-1:0] seen;
        logic                  active;
    } chg_t;

    chg_t chg_d, chg_q;

    always_comb begin
        chg_d = chg_q;
        if (rd_strobe) begin
            for (int i = 0; i < STAT_BYTES; i++) begin
                if (rd_addr == ADDR_W'(STAT_BASE + i)) begin
                    chg_d.seen[i] = 1'b1;
                end
            end
        end
        if (chg_q.active && (&chg_d.seen)) begin
            chg_d.active = 1'b0;
        end
        // a fresh event overrides a release in the same cycle
        if (evt_i) begin
            chg_d.active = 1'b1;
            chg_d.seen   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_q <= '0;
        end else begin
            chg_q <= chg_d;
        end
    end

    assign change_n = ~chg_q.active;

endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave
    import i2c_rs_pkg::*;
#(
    parameter int         DEPTH       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         CAL_ADDR    = 10,
    parameter logic [6:0] BASE_ADDR   = 7'h44,
    parameter logic [7:0] CHIP_ID     = 8'h5C,
    parameter logic [3:0] VER_MAJOR   = 4'd4,
    parameter logic [3:0] VER_MINOR   = 4'd2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe,
    input  logic [1:0]              addr_sel,
    input  logic [8*STAT_BYTES-1:0] status_i,
    input  logic                    status_evt,
    output logic                    change_n,
    output logic                    calib_o
);
    localparam int ADDR_W = $clog2(DEPTH);

    typedef struct packed {
        rs_state_e         st;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              first;
        logic              oe;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, rd_strobe;
    logic [7:0]        rd_data;
    logic [6:0]        my_addr;
    logic [ADDR_W-1:0] ptr_next;
    rs_state_e         cur_state;
    logic [ADDR_W-1:0] cur_ptr;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rs_regfile #(
        .DEPTH     (DEPTH),
        .ADDR_W    (ADDR_W),
        .CAL_ADDR  (CAL_ADDR),
        .CHIP_ID   (CHIP_ID),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (fsm_q.ptr),
        .wr_data  (fsm_q.sh),
        .rd_addr  (fsm_q.ptr),
        .status_i (status_i),
        .rd_data  (rd_data),
        .calib_o  (calib_o)
    );

    i2c_rs_chg #(.ADDR_W(ADDR_W)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (status_evt),
        .rd_strobe (rd_strobe),
        .rd_addr   (fsm_q.ptr),
        .change_n  (change_n)
    );

    assign my_addr  = {BASE_ADDR[6:2], addr_sel};
    assign ptr_next = (fsm_q.ptr == ADDR_W'(DEPTH - 1)) ? '0 : fsm_q.ptr + ADDR_W'(1);

    always_comb begin
        fsm_d     = fsm_q;
        wr_en     = 1'b0;
        rd_strobe = 1'b0;
        if (stop_det) begin
            fsm_d.st = ST_IDLE;
            fsm_d.oe = 1'b0;
        end else if (start_det) begin
            fsm_d.st  = ST_ADDR;
            fsm_d.cnt = '0;
            fsm_d.oe  = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        fsm_d.sh  = {fsm_q.sh[6:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall && fsm_q.cnt == 4'd8) begin
                        if (fsm_q.sh[7:1] == my_addr) begin
                            fsm_d.st = ST_ADDR_ACK;
                            fsm_d.oe = 1'b1;
                        end else begin
                            fsm_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.sh[0]) begin
                            fsm_d.st = ST_RD;
                            fsm_d.sh = rd_data;
                            fsm_d.oe = ~rd_data[7];
                        end else begin
                            fsm_d.st    = ST_WR;
                            fsm_d.oe    = 1'b0;
                            fsm_d.first = 1'b1;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise) begin
                        fsm_d.sh  = {fsm_q.sh[6:0], sda_s};
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall && fsm_q.cnt == 4'd8) begin
                        fsm_d.st = ST_WR_ACK;
                        fsm_d.oe = 1'b1;
                        if (fsm_q.first) begin
                            fsm_d.ptr   = fsm_q.sh[ADDR_W-1:0];
                            fsm_d.first = 1'b0;
                        end else begin
                            wr_en     = 1'b1;
                            fsm_d.ptr = ptr_next;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        fsm_d.st  = ST_WR;
                        fsm_d.oe  = 1'b0;
                        fsm_d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        fsm_d.cnt = fsm_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (fsm_q.cnt == 4'd8) begin
                            fsm_d.st  = ST_RD_ACK;
                            fsm_d.oe  = 1'b0;
                            rd_strobe = 1'b1;
                            fsm_d.ptr = ptr_next;
                        end else begin
                            fsm_d.sh = {fsm_q.sh[6:0], 1'b0};
                            fsm_d.oe = ~fsm_q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise && sda_s) begin
                        fsm_d.st = ST_SKIP;
                    end else if (scl_fall) begin
                        fsm_d.st  = ST_RD;
                        fsm_d.cnt = '0;
                        fsm_d.sh  = rd_data;
                        fsm_d.oe  = ~rd_data[7];
                    end
                end
                default: begin
                    fsm_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, cnt: '0, sh: '0, ptr: '0, first: 1'b0, oe: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_oe    = fsm_q.oe;
    assign cur_state = fsm_q.st;
    assign cur_ptr   = fsm_q.ptr;

endmodule

// File: rtl/i2c_regmap_slave_chk.sv
module i2c_regmap_slave_chk
    import i2c_rs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              status_evt,
    input logic              change_n,
    input logic              calib_o,
    input logic              sda_oe,
    input logic              wr_en,
    input logic              rd_strobe,
    input rs_state_e         cur_state,
    input logic [ADDR_W-1:0] cur_ptr
);
    a_r9_evt_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
        status_evt |=> !change_n);

    a_r10_release_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(change_n) |-> $past(rd_strobe));

    a_r8_calib_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        calib_o |=> !calib_o);

    a_r8_calib_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        calib_o |-> $past(wr_en));

    a_r12_quiet_when_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_SKIP || cur_state == ST_IDLE) |-> !sda_oe);

    a_r7_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cur_ptr == (($past(cur_ptr) == ADDR_W'(DEPTH - 1)) ? '0
                                : $past(cur_ptr) + ADDR_W'(1))));

endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_evt (status_evt),
    .change_n   (change_n),
    .calib_o    (calib_o),
    .sda_oe     (sda_oe),
    .wr_en      (wr_en),
    .rd_strobe  (rd_strobe),
    .cur_state  (cur_state),
    .cur_ptr    (cur_ptr)
);

// File: tb/i2c_regmap_slave_tb.sv
module i2c_regmap_slave_tb;
    localparam int T = 8;
    localparam logic [7:0] SLA_W   = 8'h8C;
    localparam logic [7:0] SLA_R   = 8'h8D;
    localparam logic [7:0] BAD_W   = 8'h88;
    localparam logic [7:0] ID_B    = 8'h5C;
    localparam logic [7:0] VER_B   = 8'h42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic [39:0] status_v = 40'hE1_D2_C3_B4_A5;
    logic        status_evt = 1'b0;
    logic        sda_oe, change_n, calib_o;
    logic        sda_line;

    int checks = 0;
    int fails = 0;
    int cal_cnt = 0;
    bit oe_seen = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       got_ev;
    logic [7:0] got_b;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regmap_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .addr_sel   (addr_sel),
        .status_i   (status_v),
        .status_evt (status_evt),
        .change_n   (change_n),
        .calib_o    (calib_o)
    );

    always @(negedge clk) begin
        if (calib_o) cal_cnt++;
        if (sda_oe) oe_seen = 1;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(got_ev);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: actual=%0h expected=none", got_b);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (got_b !== e) begin
                    fails++;
                    $display("FAIL %s: actual=%0h expected=%0h", t, got_b, e);
                end
            end
        end
    end

    task automatic expect_byte(string tag, logic [7:0] b);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1; scl_m = 1; wt(T);
        sda_m = 0; wt(T);
        scl_m = 0; wt(T);
    endtask

    task automatic i2c_stop();
        sda_m = 0; wt(T);
        scl_m = 1; wt(T);
        sda_m = 1; wt(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(T);
            scl_m = 1; wt(2 * T);
            scl_m = 0; wt(T);
        end
        sda_m = 1; wt(T);
        scl_m = 1; wt(T);
        acked = !sda_line;
        wt(T);
        scl_m = 0; wt(T);
    endtask

    task automatic recv_byte(input bit ack, input bit inj, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wt(T);
            scl_m = 1; wt(T);
            b[i] = sda_line;
            wt(T);
            scl_m = 0;
            if (i == 0 && inj) begin
                // event sampled on the edge that registers this SCL fall
                wt(2); status_evt = 1;
                wt(1); status_evt = 0;
                wt(T - 3);
            end else begin
                wt(T);
            end
        end
        sda_m = ~ack; wt(T);
        scl_m = 1; wt(2 * T);
        scl_m = 0; wt(T);
        sda_m = 1;
    endtask

    task automatic set_ptr(string req, logic [7:0] p);
        bit a;
        i2c_start();
        send_byte(SLA_W, a); check({req, " addr ack"}, a, 1);
        send_byte(p, a);     check({req, " ptr ack"}, a, 1);
        i2c_stop();
    endtask

    task automatic read_n(string req, int n, bit inj_last);
        bit a;
        logic [7:0] b;
        i2c_start();
        send_byte(SLA_R, a); check({req, " read addr ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, inj_last && (k == n - 1), b);
            got_b = b;
            -> got_ev;
        end
        i2c_stop();
    endtask

    task automatic pulse_evt();
        status_evt = 1; wt(1);
        status_evt = 0; wt(3);
    endtask

    initial begin
        bit a;
        // R1: reset state
        wt(5);
        check("R1 change_n", change_n, 1);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 calib_o", calib_o, 0);
        rst_n = 1; wt(5);
        check("R1 change_n after release", change_n, 1);
        check("R1 sda_oe after release", sda_oe, 0);

        // R12: foreign address ignored
        oe_seen = 0;
        i2c_start();
        send_byte(BAD_W, a); check("R12 no addr ack", a, 0);
        send_byte(8'h08, a); check("R12 no data ack", a, 0);
        send_byte(8'hFF, a); check("R12 no data ack 2", a, 0);
        i2c_stop();
        check("R12 sda never driven", oe_seen, 0);

        // R2, R3: write pointer 8 then A5, 3C, 00 (to 10), 77
        i2c_start();
        send_byte(SLA_W, a); check("R2 addr ack", a, 1);
        send_byte(8'h08, a); check("R3 ptr ack", a, 1);
        send_byte(8'hA5, a); check("R3 data ack", a, 1);
        send_byte(8'h3C, a); check("R3 data ack", a, 1);
        send_byte(8'h00, a); check("R8 zero cmd ack", a, 1);
        send_byte(8'h77, a); check("R3 data ack", a, 1);
        i2c_stop();
        check("R8 zero write gives no pulse", cal_cnt, 0);

        // R4: read from 8, then continue without reloading
        set_ptr("R4", 8'h08);
        expect_byte("R4 byte at 8", 8'hA5);
        expect_byte("R4 byte at 9", 8'h3C);
        read_n("R4", 2, 0);
        expect_byte("R8 cmd reads zero", 8'h00);
        expect_byte("R4 continue at 11", 8'h77);
        read_n("R4", 2, 0);
        // R12: bytes sent to the foreign address must not have reached 8
        set_ptr("R12", 8'h08);
        expect_byte("R12 cell 8 untouched", 8'hA5);
        read_n("R12", 1, 0);

        // R5: identity and version
        set_ptr("R5", 8'h00);
        expect_byte("R5 id", ID_B);
        expect_byte("R5 version", VER_B);
        read_n("R5", 2, 0);

        // R6: read-only window
        i2c_start();
        send_byte(SLA_W, a); check("R6 addr ack", a, 1);
        send_byte(8'h00, a); check("R6 ptr ack", a, 1);
        for (int k = 0; k < 7; k++) begin
            send_byte(8'hFF, a); check("R6 data ack", a, 1);
        end
        i2c_stop();
        set_ptr("R6", 8'h00);
        expect_byte("R6 id kept", ID_B);
        expect_byte("R6 version kept", VER_B);
        expect_byte("R6 status byte0", 8'hA5);
        expect_byte("R6 status byte1", 8'hB4);
        expect_byte("R6 status byte2", 8'hC3);
        expect_byte("R6 status byte3", 8'hD2);
        expect_byte("R6 status byte4", 8'hE1);
        read_n("R6", 7, 0);
        check("R10 no event so line idle", change_n, 1);

        // R7: wrap
        i2c_start();
        send_byte(SLA_W, a); check("R7 addr ack", a, 1);
        send_byte(8'h0F, a); check("R7 ptr ack", a, 1);
        send_byte(8'h11, a); check("R7 data ack", a, 1);
        send_byte(8'h99, a); check("R7 wrapped data ack", a, 1);
        i2c_stop();
        set_ptr("R7", 8'h0F);
        expect_byte("R7 top cell", 8'h11);
        expect_byte("R7 wrapped to id", ID_B);
        read_n("R7", 2, 0);

        // R8: nonzero command
        cal_cnt = 0;
        i2c_start();
        send_byte(SLA_W, a); check("R8 addr ack", a, 1);
        send_byte(8'h0A, a); check("R8 ptr ack", a, 1);
        send_byte(8'h07, a); check("R8 cmd ack", a, 1);
        i2c_stop();
        check("R8 one-cycle pulse", cal_cnt, 1);

        // R9, R10: event then staged status reads
        pulse_evt();
        check("R9 line low after event", change_n, 0);
        set_ptr("R10", 8'h06);
        expect_byte("R10 status 6", 8'hE1);
        read_n("R10", 1, 0);
        check("R10 one status read keeps low", change_n, 0);
        set_ptr("R10", 8'h02);
        expect_byte("R10 s2", 8'hA5);
        expect_byte("R10 s3", 8'hB4);
        expect_byte("R10 s4", 8'hC3);
        read_n("R10", 3, 0);
        check("R10 four of five keeps low", change_n, 0);
        expect_byte("R10 s5", 8'hD2);
        read_n("R10", 1, 0);
        check("R10 all five releases", change_n, 1);

        // R11: event coincides with completing read
        pulse_evt();
        check("R9 line low again", change_n, 0);
        set_ptr("R11", 8'h02);
        expect_byte("R11 s2", 8'hA5);
        expect_byte("R11 s3", 8'hB4);
        expect_byte("R11 s4", 8'hC3);
        expect_byte("R11 s5", 8'hD2);
        expect_byte("R11 s6", 8'hE1);
        read_n("R11", 5, 1);
        check("R11 event wins over release", change_n, 0);
        set_ptr("R11", 8'h06);
        expect_byte("R11 s6 again", 8'hE1);
        read_n("R11", 1, 0);
        check("R11 record was cleared", change_n, 0);
        set_ptr("R11", 8'h02);
        expect_byte("R11 s2b", 8'hA5);
        expect_byte("R11 s3b", 8'hB4);
        expect_byte("R11 s4b", 8'hC3);
        expect_byte("R11 s5b", 8'hD2);
        expect_byte("R11 s6b", 8'hE1);
        read_n("R11", 5, 0);
        check("R11 full set releases", change_n, 1);

        check("scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule